// File: doc/BRIEF.md
# Multi-CPU Interrupt Priority Arbiter

This block keeps the per-source state of an interrupt distributor: enable, pending (one bit per CPU), trigger mode, CPU target set and an 8-bit priority. It holds this for a parameterised number of interrupt IDs and CPUs. External interrupt wires come in at ID 32 and upward. A rising wire, or a level wire that is already high when its source is enabled, turns into pending bits for the CPUs that the source targets. A single command strobe port lets a bus decoder set or clear enables and pending bits and configure a source.

For every CPU, a combinational tournament tree picks the most urgent source that is both enabled and pending for that CPU. A per-CPU register then qualifies the winner against four things: the global enable, the CPU's interface enable, its priority mask and the priority of the interrupt it is already running. The register then publishes an ID and a request line. The ID 1023 means that nothing qualifies.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every request line is low and every published ID is 1023. IDs 0 to 15 start enabled. Every ID starts with priority 0, an empty target set and no pending bits. IDs 32 and up start level-triggered.
- R2: Among sources that are enabled and pending for a CPU, the one with the numerically lowest priority wins. On equal priority the lower ID wins.
- R3: A CPU publishes the winner's ID only when the winner's priority is less than or equal to that CPU's priority mask. Otherwise, or when no source is eligible, it publishes 1023.
- R4: A CPU's request line is high only when an ID is published and the winner's priority is strictly below that CPU's 9-bit running priority. The value 0x100 means idle, and the value 0 blocks every request.
- R5: While `dist_en` or the CPU's `cpu_if_en` bit is low, that CPU's request is low and its ID is 1023.
- R6: External wire k is ID 32+k. A low-to-high transition sets the source's pending bits for its targets if the source is edge-triggered or enabled (the enable as updated by a command in the same cycle). A high-to-low transition leaves pending bits alone.
- R7: A set-enable command on a level-triggered source whose wire was high in the previous cycle sets its pending bits for its targets.
- R8: Set-pending (op 3) ORs the target set into the pending bits. Clear-pending (op 4) clears the pending bits of every CPU. When a clear-pending command and a pending-setting wire rise hit the same source in one cycle, the source ends up pending.
- R9: Clear-enable (op 2) has no effect on IDs 0 to 15. Those IDs, and every ID below 32, remain edge-triggered whatever a configure command asks.
- R10: A command or wire change sampled at clock edge k alters the outputs after edge k+1. A change on `dist_en`, `cpu_if_en`, `prio_mask` or `run_prio` sampled at edge k alters them after edge k.
- R11: `cmd_op` encodes 0 none, 1 set-enable, 2 clear-enable, 3 set-pending, 4 clear-pending, 5 configure. Configure loads `cmd_prio`, `cmd_target` and `cmd_edge` (1 = edge). A command whose `cmd_id` is N_IRQ or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | N_IRQ-32 | External interrupt wires, bit k is ID 32+k |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | N_CPU | Per-CPU interface enable |
| prio_mask | input | 8*N_CPU | Per-CPU priority mask, CPU c at bits [8c+7:8c] |
| run_prio | input | 9*N_CPU | Per-CPU running priority, 0x100 = idle |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command operation code |
| cmd_id | input | 10 | Command target ID |
| cmd_edge | input | 1 | Trigger mode for configure, 1 = edge |
| cmd_target | input | N_CPU | CPU target set for configure |
| cmd_prio | input | 8 | Priority for configure |
| cpu_irq | output | N_CPU | Per-CPU request line |
| cpu_pend_id | output | 10*N_CPU | Per-CPU published ID, CPU c at bits [10c+9:10c] |

## Verification
Two paths can write the pending state of one source in the same cycle: a command on the strobe port and an edge on its external wire. The bench provokes this by raising a wire in the very cycle a clear-pending command names that source, and again when set-enable meets a rising level wire. The outcome is judged through the published ID two edges later. A random phase then overlaps commands, wire toggles and qualifier changes freely. A behavioural model that orders these updates the way the requirements state is compared against both outputs of every CPU on every clock.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
   localparam int ID_W     = 10;
   localparam int PRIO_W   = 8;
   localparam int RUN_W    = PRIO_W + 1;
   localparam int EXT_BASE = 32;
   localparam int FIXED_EN = 16;
   localparam logic [ID_W-1:0] NO_ID = 10'd1023;

   typedef enum logic [2:0] {
      OP_NONE     = 3'd0,
      OP_SET_EN   = 3'd1,
      OP_CLR_EN   = 3'd2,
      OP_SET_PEND = 3'd3,
      OP_CLR_PEND = 3'd4,
      OP_CFG      = 3'd5
   } op_e;
endpackage

// File: rtl/irqarb_slot.sv
module irqarb_slot
   import irqarb_pkg::*;
#(
   parameter int N_CPU   = 2,
   parameter int SLOT_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ID_W-1:0]   cmd_id,
   input  logic              cmd_edge,
   input  logic [N_CPU-1:0]  cmd_target,
   input  logic [PRIO_W-1:0] cmd_prio,
   output logic              en_o,
   output logic [N_CPU-1:0]  pend_o,
   output logic [PRIO_W-1:0] prio_o
);
   localparam bit HAS_LINE   = (SLOT_ID >= EXT_BASE);
   localparam bit FORCE_EDGE = (SLOT_ID <  EXT_BASE);
   localparam bit LOCKED_EN  = (SLOT_ID <  FIXED_EN);
   localparam logic [ID_W-1:0] MY_ID = ID_W'(SLOT_ID);

   op_e               op;
   logic              hit;
   logic              en_q, en_n;
   logic              edge_q;
   logic              lvl_q;
   logic              rise;
   logic [N_CPU-1:0]  pend_q, pend_n;
   logic [N_CPU-1:0]  tgt_q;
   logic [PRIO_W-1:0] prio_q;

   assign op  = op_e'(cmd_op);
   assign hit = cmd_valid && (cmd_id == MY_ID);

   generate
      if (HAS_LINE) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= line_in;
         end
         assign rise = line_in & ~lvl_q;
      end else begin : g_noline
         logic unused_line;
         assign unused_line = line_in;
         assign lvl_q = 1'b0;
         assign rise  = 1'b0;
      end
   endgenerate

   always_comb begin
      en_n = en_q;
      if (hit && op == OP_SET_EN) en_n = 1'b1;
      if (hit && op == OP_CLR_EN && !LOCKED_EN) en_n = 1'b0;

      pend_n = pend_q;
      if (hit && op == OP_CLR_PEND) pend_n = '0;
      if (hit && op == OP_SET_PEND) pend_n = pend_n | tgt_q;
      if (hit && op == OP_SET_EN && !edge_q && lvl_q) pend_n = pend_n | tgt_q;
      if (rise && (edge_q || en_n)) pend_n = pend_n | tgt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= LOCKED_EN;
         edge_q <= FORCE_EDGE;
         pend_q <= '0;
         tgt_q  <= '0;
         prio_q <= '0;
      end else begin
         en_q   <= en_n;
         pend_q <= pend_n;
         if (hit && op == OP_CFG) begin
            edge_q <= FORCE_EDGE ? 1'b1 : cmd_edge;
            tgt_q  <= cmd_target;
            prio_q <= cmd_prio;
         end
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign prio_o = prio_q;
endmodule

// File: rtl/irqarb_tree.sv
module irqarb_tree
   import irqarb_pkg::*;
#(
   parameter int N_IRQ = 64
) (
   input  logic [N_IRQ-1:0]        elig,
   input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
   output logic                    best_v,
   output logic [PRIO_W-1:0]       best_p,
   output logic [ID_W-1:0]         best_id
);
   localparam int LEAVES = 1 << $clog2(N_IRQ);
   localparam int NODES  = 2 * LEAVES;

   logic              nv  [NODES];
   logic [PRIO_W-1:0] np  [NODES];
   logic [ID_W-1:0]   nid [NODES];

   assign nv[0]  = 1'b0;
   assign np[0]  = '0;
   assign nid[0] = NO_ID;

   generate
      for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
         if (l < N_IRQ) begin : g_real
            assign nv[LEAVES+l]  = elig[l];
            assign np[LEAVES+l]  = prio_flat[l*PRIO_W +: PRIO_W];
            assign nid[LEAVES+l] = ID_W'(l);
         end else begin : g_pad
            assign nv[LEAVES+l]  = 1'b0;
            assign np[LEAVES+l]  = '1;
            assign nid[LEAVES+l] = NO_ID;
         end
      end
      for (genvar n = 1; n < LEAVES; n++) begin : g_node
         logic take_l;
         assign take_l = nv[2*n] && (!nv[2*n+1] || (np[2*n] <= np[2*n+1]));
         assign nv[n]  = nv[2*n] | nv[2*n+1];
         assign np[n]  = take_l ? np[2*n]  : np[2*n+1];
         assign nid[n] = take_l ? nid[2*n] : nid[2*n+1];
      end
   endgenerate

   assign best_v  = nv[1];
   assign best_p  = np[1];
   assign best_id = nid[1];
endmodule

// File: rtl/irqarb_cpu_port.sv
module irqarb_cpu_port
   import irqarb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic              if_en,
   input  logic [PRIO_W-1:0] mask,
   input  logic [RUN_W-1:0]  run_prio,
   input  logic              best_v,
   input  logic [PRIO_W-1:0] best_p,
   input  logic [ID_W-1:0]   best_id,
   output logic              irq_o,
   output logic [ID_W-1:0]   id_o
);
   logic show;
   logic urgent;

   assign show   = glob_en && if_en && best_v && (best_p <= mask);
   assign urgent = ({1'b0, best_p} < run_prio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         id_o  <= NO_ID;
      end else begin
         irq_o <= show && urgent;
         id_o  <= show ? best_id : NO_ID;
      end
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irqarb_pkg::*;
#(
   parameter int N_IRQ = 64,
   parameter int N_CPU = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_IRQ-EXT_BASE-1:0] ext_irq,
   input  logic                      dist_en,
   input  logic [N_CPU-1:0]          cpu_if_en,
   input  logic [N_CPU*PRIO_W-1:0]   prio_mask,
   input  logic [N_CPU*RUN_W-1:0]    run_prio,
   input  logic                      cmd_valid,
   input  logic [2:0]                cmd_op,
   input  logic [ID_W-1:0]           cmd_id,
   input  logic                      cmd_edge,
   input  logic [N_CPU-1:0]          cmd_target,
   input  logic [PRIO_W-1:0]         cmd_prio,
   output logic [N_CPU-1:0]          cpu_irq,
   output logic [N_CPU*ID_W-1:0]     cpu_pend_id
);
   localparam int N_EXT = N_IRQ - EXT_BASE;

   generate
      if (N_IRQ <= EXT_BASE || N_IRQ > 1020) begin : g_bad_nirq
         $error("N_IRQ must lie in 33..1020");
      end
      if (N_CPU < 1 || N_CPU > 8) begin : g_bad_ncpu
         $error("N_CPU must lie in 1..8");
      end
   endgenerate

   logic [N_IRQ-1:0]        en_vec;
   logic [N_IRQ*N_CPU-1:0]  pend_flat;
   logic [N_IRQ*PRIO_W-1:0] prio_flat;

   generate
      for (genvar i = 0; i < N_IRQ; i++) begin : g_slot
         logic line;
         if (i >= EXT_BASE) begin : g_ext
            assign line = ext_irq[i-EXT_BASE];
         end else begin : g_int
            assign line = 1'b0;
         end
         irqarb_slot #(.N_CPU(N_CPU), .SLOT_ID(i)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_in    (line),
            .cmd_valid  (cmd_valid),
            .cmd_op     (cmd_op),
            .cmd_id     (cmd_id),
            .cmd_edge   (cmd_edge),
            .cmd_target (cmd_target),
            .cmd_prio   (cmd_prio),
            .en_o       (en_vec[i]),
            .pend_o     (pend_flat[i*N_CPU +: N_CPU]),
            .prio_o     (prio_flat[i*PRIO_W +: PRIO_W])
         );
      end

      for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
         logic [N_IRQ-1:0]  elig;
         logic              best_v;
         logic [PRIO_W-1:0] best_p;
         logic [ID_W-1:0]   best_id;

         always_comb begin
            for (int i = 0; i < N_IRQ; i++) begin
               elig[i] = en_vec[i] & pend_flat[i*N_CPU + c];
            end
         end

         irqarb_tree #(.N_IRQ(N_IRQ)) u_tree (
            .elig      (elig),
            .prio_flat (prio_flat),
            .best_v    (best_v),
            .best_p    (best_p),
            .best_id   (best_id)
         );

         irqarb_cpu_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_en  (dist_en),
            .if_en    (cpu_if_en[c]),
            .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
            .run_prio (run_prio[c*RUN_W +: RUN_W]),
            .best_v   (best_v),
            .best_p   (best_p),
            .best_id  (best_id),
            .irq_o    (cpu_irq[c]),
            .id_o     (cpu_pend_id[c*ID_W +: ID_W])
         );
      end
   endgenerate

   logic unused_width;
   assign unused_width = (N_EXT > 0);
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk
   import irqarb_pkg::*;
#(
   parameter int N_IRQ = 64,
   parameter int N_CPU = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  dist_en,
   input logic [N_CPU-1:0]      cpu_if_en,
   input logic [N_CPU*RUN_W-1:0] run_prio,
   input logic [N_CPU-1:0]      cpu_irq,
   input logic [N_CPU*ID_W-1:0] cpu_pend_id
);
   generate
      for (genvar c = 0; c < N_CPU; c++) begin : g_chk
         // R5
         gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!dist_en || !cpu_if_en[c]) |=>
               (!cpu_irq[c] && cpu_pend_id[c*ID_W +: ID_W] == NO_ID));

         // R4
         req_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> (cpu_pend_id[c*ID_W +: ID_W] != NO_ID));

         // R4
         zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_prio[c*RUN_W +: RUN_W] == '0) |=> !cpu_irq[c]);

         // R3
         id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_pend_id[c*ID_W +: ID_W] == NO_ID) ||
            (cpu_pend_id[c*ID_W +: ID_W] < ID_W'(N_IRQ)));
      end
   endgenerate
endmodule

bind irq_prio_arbiter irqarb_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dist_en     (dist_en),
   .cpu_if_en   (cpu_if_en),
   .run_prio    (run_prio),
   .cpu_irq     (cpu_irq),
   .cpu_pend_id (cpu_pend_id)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
   localparam int CLK_P = 10;
   localparam int NI = 64;
   localparam int NC = 2;
   localparam int NE = NI - 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NE-1:0]   ext = '0;
   logic            dist_en = 1'b0;
   logic [NC-1:0]   if_en = '0;
   logic [NC*8-1:0] mask = {NC{8'hF0}};
   logic [NC*9-1:0] runp = {NC{9'h100}};
   logic            cmd_valid = 1'b0;
   logic [2:0]      cmd_op = '0;
   logic [9:0]      cmd_id = '0;
   logic            cmd_edge = 1'b0;
   logic [NC-1:0]   cmd_tgt = '0;
   logic [7:0]      cmd_prio = '0;
   logic [NC-1:0]   irq;
   logic [NC*10-1:0] pid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          m_en   [NI];
   bit          m_edge [NI];
   bit [NC-1:0] m_pend [NI];
   bit [NC-1:0] m_tgt  [NI];
   int          m_prio [NI];
   bit          m_lvl  [NE];
   bit          exp_irq [NC];
   int          exp_id  [NC];

   always #(CLK_P/2) clk = ~clk;

   irq_prio_arbiter #(.N_IRQ(NI), .N_CPU(NC)) u_irq_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext), .dist_en(dist_en),
      .cpu_if_en(if_en), .prio_mask(mask), .run_prio(runp),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
      .cmd_edge(cmd_edge), .cmd_target(cmd_tgt), .cmd_prio(cmd_prio),
      .cpu_irq(irq), .cpu_pend_id(pid)
   );

   task automatic model_reset();
      for (int i = 0; i < NI; i++) begin
         m_en[i] = (i < 16); m_edge[i] = (i < 32);
         m_pend[i] = '0; m_tgt[i] = '0; m_prio[i] = 0;
      end
      for (int k = 0; k < NE; k++) m_lvl[k] = 1'b0;
   endtask

   task automatic model_eval();
      for (int c = 0; c < NC; c++) begin
         int best = -1;
         int bp = 256;
         bit show;
         for (int i = 0; i < NI; i++)
            if (m_en[i] && m_pend[i][c] && m_prio[i] < bp) begin
               best = i; bp = m_prio[i];
            end
         show = dist_en && if_en[c] && best >= 0 && bp <= int'(mask[c*8 +: 8]);
         exp_id[c]  = show ? best : 1023;
         exp_irq[c] = show && (bp < int'(runp[c*9 +: 9]));
      end
   endtask

   task automatic model_update();
      for (int i = 0; i < NI; i++) begin
         bit hit = cmd_valid && (int'(cmd_id) == i);
         bit en_n = m_en[i];
         bit [NC-1:0] p = m_pend[i];
         bit rise = 1'b0;
         bit lvl = 1'b0;
         if (i >= 32) begin
            lvl  = m_lvl[i-32];
            rise = ext[i-32] && !lvl;
         end
         if (hit && cmd_op == 3'd1) en_n = 1'b1;
         if (hit && cmd_op == 3'd2 && i >= 16) en_n = 1'b0;
         if (hit && cmd_op == 3'd4) p = '0;
         if (hit && cmd_op == 3'd3) p |= m_tgt[i];
         if (hit && cmd_op == 3'd1 && !m_edge[i] && lvl) p |= m_tgt[i];
         if (rise && (m_edge[i] || en_n)) p |= m_tgt[i];
         m_en[i] = en_n;
         m_pend[i] = p;
         if (hit && cmd_op == 3'd5) begin
            m_prio[i] = int'(cmd_prio);
            m_tgt[i]  = cmd_tgt;
            m_edge[i] = (i < 32) ? 1'b1 : cmd_edge;
         end
      end
      for (int k = 0; k < NE; k++) m_lvl[k] = ext[k];
   endtask

   task automatic tick(input string tag);
      if (!rst_n) begin
         model_reset();
         for (int c = 0; c < NC; c++) begin exp_irq[c] = 1'b0; exp_id[c] = 1023; end
      end else begin
         model_eval();
         model_update();
      end
      @(posedge clk);
      #1;
      for (int c = 0; c < NC; c++) begin
         checks++;
         if (irq[c] !== exp_irq[c]) begin
            errors++;
            $display("FAIL %s cpu%0d irq got %b exp %b", tag, c, irq[c], exp_irq[c]);
         end
         checks++;
         if (int'(pid[c*10 +: 10]) != exp_id[c]) begin
            errors++;
            $display("FAIL %s cpu%0d id got %0d exp %0d", tag, c, pid[c*10 +: 10], exp_id[c]);
         end
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int j = 0; j < n; j++) tick(tag);
   endtask

   task automatic cmd(input int op, input int id, input bit edg, input int tgt,
                      input int pr, input string tag);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_id = 10'(id);
      cmd_edge = edg; cmd_tgt = NC'(tgt); cmd_prio = 8'(pr);
      tick(tag);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog got hang exp finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3, "R1");
      rst_n = 1'b1;
      idle(2, "R1");
      dist_en = 1'b1; if_en = '1;
      idle(1, "R5");
      // R1: ID 3 is enabled out of reset
      cmd(5, 3, 0, 1, 8'h40, "R1");
      cmd(3, 3, 0, 0, 0, "R1");
      idle(2, "R1");
      // R2: tie on priority, then a more urgent source
      cmd(5, 40, 1, 3, 8'h20, "R2");
      cmd(5, 41, 1, 3, 8'h20, "R2");
      cmd(1, 40, 0, 0, 0, "R2");
      cmd(1, 41, 0, 0, 0, "R2");
      ext[8] = 1'b1; ext[9] = 1'b1;
      idle(3, "R2");
      cmd(5, 41, 1, 3, 8'h10, "R2");
      idle(2, "R2");
      // R3: mask below and equal to the winner
      mask[15:8] = 8'h0F; idle(2, "R3");
      mask[15:8] = 8'h10; idle(2, "R3");
      mask[15:8] = 8'hF0;
      // R4: running priority equal, then one above
      runp[8:0] = 9'h010; idle(2, "R4");
      runp[8:0] = 9'h011; idle(2, "R4");
      runp[8:0] = 9'h000; idle(2, "R4");
      runp[8:0] = 9'h100;
      // R5
      if_en = 2'b01; idle(2, "R5");
      if_en = 2'b11; dist_en = 1'b0; idle(2, "R5");
      dist_en = 1'b1; idle(1, "R10");
      cmd(4, 41, 0, 0, 0, "R8");
      cmd(4, 40, 0, 0, 0, "R8");
      cmd(4, 3, 0, 0, 0, "R8");
      idle(2, "R8");
      ext[8] = 1'b0; ext[9] = 1'b0; idle(2, "R6");
      // R6 and R7: level source rises while disabled, then is enabled
      cmd(5, 50, 0, 2, 8'h30, "R6");
      ext[18] = 1'b1; idle(2, "R6");
      cmd(1, 50, 0, 0, 0, "R7");
      idle(2, "R7");
      ext[18] = 1'b0; idle(2, "R6");
      cmd(4, 50, 0, 0, 0, "R8");
      // R6: edge source latches while disabled
      cmd(5, 45, 1, 1, 8'h50, "R6");
      ext[13] = 1'b1; idle(2, "R6");
      ext[13] = 1'b0; idle(2, "R6");
      cmd(1, 45, 0, 0, 0, "R6");
      idle(2, "R6");
      // R8: clear-pending and wire rise in the same cycle
      ext[13] = 1'b1;
      cmd(4, 45, 0, 0, 0, "R8");
      idle(2, "R8");
      ext[13] = 1'b0;
      cmd(4, 45, 0, 0, 0, "R8");
      // R9: clear-enable on a fixed-enable ID
      cmd(5, 5, 0, 3, 8'h05, "R9");
      cmd(3, 5, 0, 0, 0, "R9");
      cmd(2, 5, 0, 0, 0, "R9");
      idle(2, "R9");
      // R11: out-of-range IDs
      cmd(5, 64, 1, 3, 8'h00, "R11");
      cmd(3, 64, 0, 0, 0, "R11");
      cmd(3, 100, 0, 0, 0, "R11");
      idle(2, "R11");
      // R10: free-running mix
      for (int n = 0; n < 600; n++) begin
         if ($urandom_range(0, 3) == 0) begin
            int k = int'($urandom_range(0, NE-1));
            ext[k] = ~ext[k];
         end
         if ($urandom_range(0, 15) == 0) if_en = NC'($urandom_range(0, 3));
         if ($urandom_range(0, 31) == 0) dist_en = ~dist_en;
         if ($urandom_range(0, 15) == 0) runp[8:0] = 9'($urandom_range(0, 256));
         if ($urandom_range(0, 15) == 0) mask[15:8] = 8'($urandom_range(0, 255));
         if ($urandom_range(0, 1) == 0)
            cmd(int'($urandom_range(0, 5)), int'($urandom_range(0, 70)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 255)), "R10");
         else
            tick("R10");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule